// File: doc/BRIEF.md
# Vector Byte Shuffle Unit

This block rearranges the bytes and bits of 128-bit vectors. It takes three source vectors A, B and C and a two-bit operation code. It returns one 128-bit result. It has four operations:

- Permute: every result byte is taken from A or B, as steered by the matching control byte in C.
- Select: a bit-wise blend of A and B, with C as the mask.
- Byte merge: interleaves the upper eight bytes of A and B.
- Halfword merge: interleaves the upper four halfwords of A and B.

Elements are counted from the most significant end, so byte 0 is bits [127:120].

The datapath is purely combinational. A parameter `OUT_REG` can add one register stage at the output. That register clears on reset and loads on every clock edge. The block has no state machine; its only sequential element is that optional register.

Operation encoding on `op_i`:

| Value | Operation |
|-------|-----------|
| 0 | Permute |
| 1 | Select |
| 2 | Byte merge |
| 3 | Halfword merge |

Top module: `vec_shuffle_unit`

## Requirements
- R1: In permute (op 0), result byte i comes from B when bit 4 of control byte i of C is 1, and from A when that bit is 0.
- R2: In permute, bits 3:0 of control byte i give the byte number within the chosen source. Control bits 7:5 have no effect on the result.
- R3: In select (op 1), each of the 128 result bits equals the B bit where the matching C bit is 1, and the A bit where it is 0.
- R4: In byte merge (op 2), the result bytes 0..15 are A0, B0, A1, B1, and so on up to A7, B7. Source C has no effect.
- R5: In halfword merge (op 3), the result halfwords 0..7 are A0, B0, A1, B1, A2, B2, A3, B3, where halfword k is bits [127-16k -: 16]. Source C has no effect.
- R6: Byte k of every vector occupies bits [127-8k -: 8], so byte 0 is the most significant byte and byte 15 the least significant.
- R7: With OUT_REG=0, `res_o` is a function of the present inputs only and is valid in the same cycle. This holds even while reset is asserted.
- R8: With OUT_REG=1, `res_o` shows the result of the inputs present at the previous rising clock edge. While `rst_n` is low, `res_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation code: 0 permute, 1 select, 2 byte merge, 3 halfword merge |
| src_a_i | input | 128 | Source vector A |
| src_b_i | input | 128 | Source vector B |
| src_c_i | input | 128 | Source vector C: permute control bytes or select mask |
| res_o | output | 128 | Result vector |

## Verification
With OUT_REG=0 the result is due in the same cycle as the inputs. The bench changes the inputs on the falling edge and samples the unregistered copy one nanosecond later, before any rising edge. The registered copy is due one rising edge after the inputs were applied, so the bench samples it one nanosecond after that edge, while the inputs are still held. During reset the registered copy is sampled for zero, and the unregistered copy is checked to keep computing.

// File: rtl/vshuf_pkg.sv
package vshuf_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_PERMUTE = 2'd0,
        OP_SELECT  = 2'd1,
        OP_MRG_B   = 2'd2,
        OP_MRG_H   = 2'd3
    } shuf_op_e;

endpackage

// File: rtl/vshuf_permute.sv
module vshuf_permute #(
    parameter int NBYTES = 16
) (
    input  logic [NBYTES*vshuf_pkg::BYTE_W-1:0] a_i,
    input  logic [NBYTES*vshuf_pkg::BYTE_W-1:0] b_i,
    input  logic [NBYTES*vshuf_pkg::BYTE_W-1:0] ctl_i,
    output logic [NBYTES*vshuf_pkg::BYTE_W-1:0] y_o
);
    import vshuf_pkg::*;

    localparam int VEC_W = NBYTES * BYTE_W;
    localparam int IDX_W = $clog2(NBYTES);

    logic [BYTE_W-1:0] a_byte [NBYTES];
    logic [BYTE_W-1:0] b_byte [NBYTES];

    // Byte k sits at the most-significant end for k = 0.
    generate
        for (genvar k = 0; k < NBYTES; k++) begin : g_split
            assign a_byte[k] = a_i[VEC_W-1-BYTE_W*k -: BYTE_W];
            assign b_byte[k] = b_i[VEC_W-1-BYTE_W*k -: BYTE_W];
        end
    endgenerate

    generate
        for (genvar i = 0; i < NBYTES; i++) begin : g_lane
            logic [BYTE_W-1:0] ctl;
            logic [IDX_W-1:0]  idx;
            logic              from_b;
            logic              unused_ctl_hi;

            assign ctl           = ctl_i[VEC_W-1-BYTE_W*i -: BYTE_W];
            assign idx           = ctl[IDX_W-1:0];
            assign from_b        = ctl[IDX_W];
            assign unused_ctl_hi = ^ctl[BYTE_W-1:IDX_W+1];

            assign y_o[VEC_W-1-BYTE_W*i -: BYTE_W] = from_b ? b_byte[idx] : a_byte[idx];
        end
    endgenerate

endmodule

// File: rtl/vshuf_select.sv
module vshuf_select #(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  logic [VEC_W-1:0] mask_i,
    output logic [VEC_W-1:0] y_o
);

    assign y_o = (b_i & mask_i) | (a_i & ~mask_i);

endmodule

// File: rtl/vshuf_merge.sv
module vshuf_merge #(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 8
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    output logic [VEC_W-1:0] y_o
);

    localparam int NELEM = VEC_W / ELEM_W;
    localparam int HALF  = NELEM / 2;

    logic unused_low;
    assign unused_low = ^{a_i[VEC_W/2-1:0], b_i[VEC_W/2-1:0]};

    generate
        for (genvar j = 0; j < HALF; j++) begin : g_pair
            assign y_o[VEC_W-1-ELEM_W*(2*j)   -: ELEM_W] = a_i[VEC_W-1-ELEM_W*j -: ELEM_W];
            assign y_o[VEC_W-1-ELEM_W*(2*j+1) -: ELEM_W] = b_i[VEC_W-1-ELEM_W*j -: ELEM_W];
        end
    endgenerate

endmodule

// File: rtl/vec_shuffle_unit.sv
module vec_shuffle_unit #(
    parameter int NBYTES  = 16,
    parameter bit OUT_REG = 1'b0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [1:0]                         op_i,
    input  logic [NBYTES*vshuf_pkg::BYTE_W-1:0] src_a_i,
    input  logic [NBYTES*vshuf_pkg::BYTE_W-1:0] src_b_i,
    input  logic [NBYTES*vshuf_pkg::BYTE_W-1:0] src_c_i,
    output logic [NBYTES*vshuf_pkg::BYTE_W-1:0] res_o
);
    import vshuf_pkg::*;

    localparam int VEC_W  = NBYTES * BYTE_W;
    localparam int HALF_W = 2 * BYTE_W;

    shuf_op_e          op;
    logic [VEC_W-1:0]  perm_y;
    logic [VEC_W-1:0]  sel_y;
    logic [VEC_W-1:0]  mrg_b_y;
    logic [VEC_W-1:0]  mrg_h_y;
    logic [VEC_W-1:0]  comb_y;

    assign op = shuf_op_e'(op_i);

    vshuf_permute #(.NBYTES(NBYTES)) u_perm (
        .a_i(src_a_i), .b_i(src_b_i), .ctl_i(src_c_i), .y_o(perm_y)
    );

    vshuf_select #(.VEC_W(VEC_W)) u_sel (
        .a_i(src_a_i), .b_i(src_b_i), .mask_i(src_c_i), .y_o(sel_y)
    );

    vshuf_merge #(.VEC_W(VEC_W), .ELEM_W(BYTE_W)) u_mrg_b (
        .a_i(src_a_i), .b_i(src_b_i), .y_o(mrg_b_y)
    );

    vshuf_merge #(.VEC_W(VEC_W), .ELEM_W(HALF_W)) u_mrg_h (
        .a_i(src_a_i), .b_i(src_b_i), .y_o(mrg_h_y)
    );

    always_comb begin
        unique case (op)
            OP_PERMUTE: comb_y = perm_y;
            OP_SELECT:  comb_y = sel_y;
            OP_MRG_B:   comb_y = mrg_b_y;
            OP_MRG_H:   comb_y = mrg_h_y;
            default:    comb_y = '0;
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            logic [VEC_W-1:0] res_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= comb_y;
            end
            assign res_o = res_q;

            p_reg_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> res_o == $past(comb_y));
        end else begin : g_comb
            assign res_o = comb_y;
        end
    endgenerate

    // R3: where the mask is 0 the result copies A, where it is 1 it copies B.
    p_sel_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_SELECT |-> (((comb_y ^ src_a_i) & ~src_c_i) == '0) &&
                            (((comb_y ^ src_b_i) &  src_c_i) == '0));

    // R1: all control bytes steering to A with A all zero gives a zero result.
    p_perm_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PERMUTE && src_a_i == '0 &&
         (src_c_i & {NBYTES{8'h10}}) == '0) |-> comb_y == '0);

    // R4: the leading byte pair comes from A then B, both at byte 0.
    p_mrg_b_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_MRG_B |-> comb_y[VEC_W-1 -: BYTE_W] == src_a_i[VEC_W-1 -: BYTE_W] &&
                           comb_y[VEC_W-1-BYTE_W -: BYTE_W] == src_b_i[VEC_W-1 -: BYTE_W]);

    // R5: the leading halfword pair comes from A then B, both at halfword 0.
    p_mrg_h_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_MRG_H |-> comb_y[VEC_W-1 -: HALF_W] == src_a_i[VEC_W-1 -: HALF_W] &&
                           comb_y[VEC_W-1-HALF_W -: HALF_W] == src_b_i[VEC_W-1 -: HALF_W]);

endmodule

// File: tb/vec_shuffle_unit_bench.sv
module vec_shuffle_unit_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   op = 2'd0;
    logic [127:0] a = '0, b = '0, c = '0;
    logic [127:0] y_comb, y_reg;
    int           n_checks = 0;
    int           n_errors = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    vec_shuffle_unit #(.NBYTES(16), .OUT_REG(1'b0)) u_vec_shuffle_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op),
        .src_a_i(a), .src_b_i(b), .src_c_i(c), .res_o(y_comb)
    );

    vec_shuffle_unit #(.NBYTES(16), .OUT_REG(1'b1)) u_vec_shuffle_unit_q (
        .clk(clk), .rst_n(rst_n), .op_i(op),
        .src_a_i(a), .src_b_i(b), .src_c_i(c), .res_o(y_reg)
    );

    function automatic logic [7:0] byt(logic [127:0] v, int k);
        return v[127-8*k -: 8];
    endfunction

    function automatic logic [127:0] pat(int seed);
        logic [127:0] v;
        for (int k = 0; k < 16; k++) v[127-8*k -: 8] = 8'((seed * 37 + k * 29 + 11 + seed * k) & 255);
        return v;
    endfunction

    function automatic logic [127:0] model(logic [1:0] o, logic [127:0] xa, logic [127:0] xb, logic [127:0] xc);
        logic [127:0] r = '0;
        case (o)
            2'd0: for (int i = 0; i < 16; i++) begin
                int s = int'(byt(xc, i)) % 16;
                r[127-8*i -: 8] = ((int'(byt(xc, i)) / 16) % 2 == 1) ? byt(xb, s) : byt(xa, s);
            end
            2'd1: for (int k = 0; k < 128; k++) r[k] = xc[k] ? xb[k] : xa[k];
            2'd2: for (int j = 0; j < 8; j++) begin
                r[127-16*j -: 8]   = byt(xa, j);
                r[119-16*j -: 8]   = byt(xb, j);
            end
            default: for (int j = 0; j < 4; j++) begin
                r[127-32*j -: 16]  = xa[127-16*j -: 16];
                r[111-32*j -: 16]  = xb[127-16*j -: 16];
            end
        endcase
        return r;
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, check the unregistered copy 1 ns later (R7)
    // and the registered copy 1 ns after the next rising edge (R8).
    task automatic apply(string tag, logic [1:0] o, logic [127:0] xa, logic [127:0] xb,
                         logic [127:0] xc, logic [127:0] exp);
        @(negedge clk);
        op = o; a = xa; b = xb; c = xc;
        #1;
        check({tag, " R7"}, y_comb, exp);
        @(posedge clk);
        #1;
        check({tag, " R8"}, y_reg, exp);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] xc;
        logic [127:0] exp;
        // Reset: registered output zero, combinational path still live (R7, R8).
        op = 2'd1; a = pat(3); b = pat(4); c = pat(5);
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset", y_reg, '0);
        check("R7 reset", y_comb, model(2'd1, pat(3), pat(4), pat(5)));
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2: permute, control byte values swept over every code.
        for (int v = 0; v < 256; v++) begin
            for (int i = 0; i < 16; i++) xc[127-8*i -: 8] = 8'((v + i * 17) & 255);
            apply("R1 R2 permute", 2'd0, pat(v), pat(v + 101), xc,
                  model(2'd0, pat(v), pat(v + 101), xc));
        end
        // R6: index 0 from A is the top byte, 0x1F is B's bottom byte.
        apply("R6 R1 perm A0", 2'd0, pat(7), pat(8), '0, {16{pat(7)[127:120]}});
        apply("R6 R1 perm B15", 2'd0, pat(7), pat(8), {16{8'h1F}}, {16{pat(8)[7:0]}});
        // R2: high control bits ignored (E5 behaves as 05).
        apply("R2 perm hi bits", 2'd0, pat(9), pat(10), {16{8'hE5}}, {16{byt(pat(9), 5)}});
        apply("R2 perm hi bits B", 2'd0, pat(9), pat(10), {16{8'hF3}}, {16{byt(pat(10), 3)}});

        // R3: select over several masks plus all-zero and all-one masks.
        for (int v = 0; v < 64; v++)
            apply("R3 select", 2'd1, pat(v + 7), pat(v + 50), pat(v + 200),
                  model(2'd1, pat(v + 7), pat(v + 50), pat(v + 200)));
        apply("R3 select zeros", 2'd1, pat(1), pat(2), '0, pat(1));
        apply("R3 select ones", 2'd1, pat(1), pat(2), '1, pat(2));

        // R4 R5: merges; C varies and must not matter.
        for (int v = 0; v < 64; v++) begin
            exp = model(2'd2, pat(v), pat(v + 33), '0);
            apply("R4 merge byte", 2'd2, pat(v), pat(v + 33), pat(v + 90), exp);
            exp = model(2'd3, pat(v), pat(v + 33), '0);
            apply("R5 merge half", 2'd3, pat(v), pat(v + 33), pat(v + 91), exp);
        end
        apply("R4 R6 merge byte fixed", 2'd2, 128'h00112233445566778899AABBCCDDEEFF,
              128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0, '1,
              128'h000F111E222D333C444B555A66697778);
        apply("R5 R6 merge half fixed", 2'd3, 128'h00112233445566778899AABBCCDDEEFF,
              128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0, '0,
              128'h00110F1E22332D3C44554B5A66776978);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule